// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Converters

This block is a purely combinational adder for two WIDTH-bit operands and a carry-in, with WIDTH set to 8, 16 or 32. It returns a WIDTH-bit sum and a carry-out. It is meant to sit on a datapath where a single ripple chain across the whole width would be too slow.

The operand bits are split into groups. The groups get wider toward the most significant end, so each group's local ripple finishes at about the same time as the carry that selects it. The lowest group is a plain 2-bit ripple adder fed by the external carry-in.

Every higher group has three parts:
- a ripple adder that assumes no incoming carry;
- an add-one converter that adds one to that raw result, carry bit included;
- a 2:1 multiplexer, steered by the carry leaving the group below, that picks one of the two results.

The carry-in-one ripple adder of a classic carry-select design is not needed. The add-one converter takes its place.

The block has no clock and no state. No handshake is placed on its edge: a result is valid whenever its operands are, and any registering belongs to the surrounding pipeline.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, {carry_out, sum_o} equals a_i + b_i + carry_in as an unsigned (WIDTH+1)-bit value, for WIDTH = 8, 16 and 32.
- R2: The lowest group covers bits [1:0] and adds them with the external carry_in. For example, all-ones plus zero with carry_in = 1 gives a zero sum and carry_out = 1.
- R3: Groups are sized from the least significant end.
  - WIDTH = 8: 2,2,4, so boundaries fall at bits 2 and 4.
  - WIDTH = 16: 2,2,3,4,5, so boundaries fall at bits 2, 4, 7 and 11.
  - WIDTH = 32: 2,2,3,4,5,7,9, so boundaries fall at bits 2, 4, 7, 11, 16 and 23.
  
  The carry entering each group equals the true carry into that bit position.
- R4: In each group above the lowest, the raw ripple result (k sum bits plus a carry) equals the sum of the group's operand slices with no carry-in.
- R5: When the carry entering an upper group is 0, the group's sum bits and its outgoing carry are the raw ripple result unchanged.
- R6: When the carry entering an upper group is 1, the group's output is the raw (k+1)-bit result plus one. Each bit is inverted exactly when all lower bits of that raw result are 1.
- R7: carry_out is the top bit of the (k+1)-bit result selected in the most significant group.
- R8: The outputs depend only on the present inputs. With all inputs at zero, sum_o and carry_out are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A wrong raw ripple result, a misbuilt add-one converter or a swapped multiplexer leg corrupts only the sum bits of its own group, plus the carry it hands upward. The error appears at the ports in the same evaluation as the offending inputs. However, it shows only for operand patterns that reach that path: an add-one fault is invisible unless the group below produces a carry. The directed vectors therefore push a carry into each group boundary, with the group's own bits both clear and all ones. This exercises both multiplexer legs and the converter's full carry ripple, including the final carry_out.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Number of groups for a supported width.
  function automatic int grp_count(input int n);
    if (n == 8)       return 3;
    else if (n == 16) return 5;
    else              return 7;
  endfunction

  // Width of group g, counted from the least significant end.
  function automatic int grp_width(input int n, input int g);
    if (n == 8) begin
      case (g)
        0, 1:    return 2;
        default: return 4;
      endcase
    end else if (n == 16) begin
      case (g)
        0, 1:    return 2;
        2:       return 3;
        3:       return 4;
        default: return 5;
      endcase
    end else begin
      case (g)
        0, 1:    return 2;
        2:       return 3;
        3:       return 4;
        4:       return 5;
        5:       return 7;
        default: return 9;
      endcase
    end
  endfunction

  // Lowest bit position of group g (grp_base(n, grp_count(n)) == n).
  function automatic int grp_base(input int n, input int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += grp_width(n, k);
    return acc;
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] chain;

  assign chain[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic half;
    assign half       = x_i[i] ^ y_i[i];
    assign s_o[i]     = half ^ chain[i];
    assign chain[i+1] = (x_i[i] & y_i[i]) | (chain[i] & half);
  end

  assign c_o = chain[W];
endmodule

// File: rtl/csel_plus_one.sv
module csel_plus_one #(
  parameter int W = 5
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] v_o
);
  // run[i] is 1 when every bit below i is 1.
  logic [W-1:0] run;

  assign run[0] = 1'b1;

  for (genvar i = 1; i < W; i++) begin : g_run
    assign run[i] = run[i-1] & v_i[i-1];
  end

  assign v_o = v_i ^ run;
endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int W = 5
) (
  input  logic         sel_i,
  input  logic [W-1:0] zero_i,
  input  logic [W-1:0] one_i,
  output logic [W-1:0] out_o
);
  assign out_o = sel_i ? one_i : zero_i;
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out
);
  localparam int NGRP = grp_count(WIDTH);

  logic [NGRP:0]    grp_cin;   // carry entering each group
  logic [WIDTH-1:0] raw_sum;   // per-group ripple sums
  logic [NGRP-1:0]  raw_cout;  // per-group ripple carries

  assign grp_cin[0] = carry_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int K  = grp_width(WIDTH, g);
    localparam int LO = grp_base(WIDTH, g);

    if (g == 0) begin : g_first
      csel_ripple #(.W(K)) u_rca (
        .x_i (a_i[LO +: K]),
        .y_i (b_i[LO +: K]),
        .c_i (carry_in),
        .s_o (raw_sum[LO +: K]),
        .c_o (raw_cout[g])
      );
      assign sum_o[LO +: K] = raw_sum[LO +: K];
      assign grp_cin[g+1]   = raw_cout[g];
    end else begin : g_upper
      logic [K:0] bumped;

      csel_ripple #(.W(K)) u_rca (
        .x_i (a_i[LO +: K]),
        .y_i (b_i[LO +: K]),
        .c_i (1'b0),
        .s_o (raw_sum[LO +: K]),
        .c_o (raw_cout[g])
      );

      csel_plus_one #(.W(K+1)) u_inc (
        .v_i ({raw_cout[g], raw_sum[LO +: K]}),
        .v_o (bumped)
      );

      csel_pick #(.W(K+1)) u_mux (
        .sel_i  (grp_cin[g]),
        .zero_i ({raw_cout[g], raw_sum[LO +: K]}),
        .one_i  (bumped),
        .out_o  ({grp_cin[g+1], sum_o[LO +: K]})
      );
    end
  end

  assign carry_out = grp_cin[NGRP];
endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk
  import csel_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int NGRP = grp_count(WIDTH)
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_out,
  input logic [NGRP:0]    grp_cin,
  input logic [WIDTH-1:0] raw_sum,
  input logic [NGRP-1:0]  raw_cout
);
  logic [WIDTH:0] ref_c;

  always_comb begin
    ref_c[0] = carry_in;
    for (int i = 0; i < WIDTH; i++)
      ref_c[i+1] = (a_i[i] & b_i[i]) | (ref_c[i] & (a_i[i] ^ b_i[i]));
  end

  // R1: whole-word result
  always_comb begin
    a_r1_sum_exact: assert ({carry_out, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_in}))
      else $error("R1 sum mismatch");
  end

  // R3: carries at group boundaries
  always_comb begin
    for (int g = 0; g <= NGRP; g++) begin
      a_r3_boundary_carry: assert (grp_cin[g] == ref_c[grp_base(WIDTH, g)])
        else $error("R3 boundary carry wrong at group %0d", g);
    end
  end

  // R4..R7: per-group raw, select and add-one behaviour
  always_comb begin
    logic c;
    logic ones;
    logic exp_top;
    int   i;
    for (int g = 0; g < NGRP; g++) begin
      c    = (g == 0) ? carry_in : 1'b0;
      ones = 1'b1;
      for (int j = 0; j < grp_width(WIDTH, g); j++) begin
        i = grp_base(WIDTH, g) + j;
        a_r4_raw_ripple: assert (raw_sum[i] == (a_i[i] ^ b_i[i] ^ c))
          else $error("R4 raw sum wrong at bit %0d", i);
        if (g > 0) begin
          if (!grp_cin[g]) begin
            a_r5_pick_raw: assert (sum_o[i] == raw_sum[i])
              else $error("R5 raw leg not taken at bit %0d", i);
          end else begin
            a_r6_pick_bumped: assert (sum_o[i] == (raw_sum[i] ^ ones))
              else $error("R6 add-one leg wrong at bit %0d", i);
          end
        end
        c    = (a_i[i] & b_i[i]) | (c & (a_i[i] ^ b_i[i]));
        ones = ones & raw_sum[i];
      end
      a_r4_raw_carry: assert (raw_cout[g] == c)
        else $error("R4 raw carry wrong in group %0d", g);
      if (g > 0) begin
        exp_top = grp_cin[g] ? (raw_cout[g] ^ ones) : raw_cout[g];
        if (g == NGRP - 1) begin
          a_r7_final_carry: assert (carry_out == exp_top)
            else $error("R7 carry_out wrong");
        end
      end
    end
  end
endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_in  (carry_in),
  .sum_o     (sum_o),
  .carry_out (carry_out),
  .grp_cin   (grp_cin),
  .raw_sum   (raw_sum),
  .raw_cout  (raw_cout)
);

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int  nchk  = 0;
  int  nfail = 0;
  bit  done  = 1'b0;

  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;

  sqrt_csel_adder #(.WIDTH(32)) u_sqrt_csel_adder (
    .a_i(a32), .b_i(b32), .carry_in(c32), .sum_o(s32), .carry_out(co32));
  sqrt_csel_adder #(.WIDTH(16)) u_sqrt_csel_adder_w16 (
    .a_i(a16), .b_i(b16), .carry_in(c16), .sum_o(s16), .carry_out(co16));
  sqrt_csel_adder #(.WIDTH(8)) u_sqrt_csel_adder_w8 (
    .a_i(a8), .b_i(b8), .carry_in(c8), .sum_o(s8), .carry_out(co8));

  task automatic chk(input string req, input longint unsigned got,
                     input longint unsigned exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic v32(input logic [31:0] a, input logic [31:0] b,
                     input logic ci, input string req);
    longint unsigned exp;
    a32 = a; b32 = b; c32 = ci;
    #1;
    exp = longint'(a) + longint'(b) + longint'(ci);
    chk(req, {31'b0, co32, s32}, exp);
    #1;
  endtask

  task automatic v16(input logic [15:0] a, input logic [15:0] b,
                     input logic ci, input string req);
    longint unsigned exp;
    a16 = a; b16 = b; c16 = ci;
    #1;
    exp = longint'(a) + longint'(b) + longint'(ci);
    chk(req, {47'b0, co16, s16}, exp);
    #1;
  endtask

  task automatic v8(input logic [7:0] a, input logic [7:0] b,
                    input logic ci, input string req);
    longint unsigned exp;
    a8 = a; b8 = b; c8 = ci;
    #1;
    exp = longint'(a) + longint'(b) + longint'(ci);
    chk(req, {55'b0, co8, s8}, exp);
    #1;
  endtask

  // R8: zero inputs give zero outputs, no clock involved
  task automatic t_reset_zero;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8  = '0; b8  = '0; c8  = 1'b0;
    @(negedge clk);
    chk("R8 w32", {31'b0, co32, s32}, 64'd0);
    chk("R8 w16", {47'b0, co16, s16}, 64'd0);
    chk("R8 w8",  {55'b0, co8, s8},   64'd0);
  endtask

  // R1: every input combination at WIDTH = 8
  task automatic t_exhaustive8;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int ci = 0; ci < 2; ci++)
          v8(8'(a), 8'(b), 1'(ci), "R1 exhaustive w8");
  endtask

  // R2, R7: all-ones patterns and alternating bits
  task automatic t_corners;
    v32('1, 32'd0, 1'b1, "R2 all-ones plus carry_in w32");
    v32('1, 32'd1, 1'b0, "R7 all-ones plus one w32");
    v32('1, '1, 1'b1, "R7 all-ones both w32");
    v32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R1 alternating cin0 w32");
    v32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R7 alternating cin1 w32");
    v32(32'h5555_5555, 32'h5555_5555, 1'b1, "R1 alternating same w32");
    v16('1, 16'd0, 1'b1, "R2 all-ones plus carry_in w16");
    v16('1, 16'd1, 1'b0, "R7 all-ones plus one w16");
    v16(16'hAAAA, 16'h5555, 1'b0, "R1 alternating cin0 w16");
    v16(16'hAAAA, 16'h5555, 1'b1, "R7 alternating cin1 w16");
    v32(32'd3, 32'd0, 1'b1, "R2 low group carry w32");
    v8(8'd3, 8'd0, 1'b1, "R2 low group carry w8");
  endtask

  // R3..R6: drive a carry into each group boundary
  task automatic t_edges32;
    int bnd [6] = '{2, 4, 7, 11, 16, 23};
    int nxt [6] = '{4, 7, 11, 16, 23, 32};
    logic [31:0] below, grp_all;
    for (int k = 0; k < 6; k++) begin
      below   = (32'd1 << bnd[k]) - 32'd1;
      grp_all = (nxt[k] == 32) ? '1 : ((32'd1 << nxt[k]) - 32'd1);
      v32(below, 32'd0, 1'b1, "R3 carry into boundary w32");
      v32(32'd3 << bnd[k], 32'd1 << bnd[k], 1'b0, "R5 raw leg w32");
      v32(grp_all, 32'd0, 1'b1, "R6 add-one ripples across group w32");
      v32(32'd5 << bnd[k], below, 1'b1, "R4 raw plus bump w32");
    end
  endtask

  task automatic t_edges16;
    int bnd [4] = '{2, 4, 7, 11};
    int nxt [4] = '{4, 7, 11, 16};
    logic [15:0] below, grp_all;
    for (int k = 0; k < 4; k++) begin
      below   = 16'((32'd1 << bnd[k]) - 32'd1);
      grp_all = 16'((32'd1 << nxt[k]) - 32'd1);
      v16(below, 16'd0, 1'b1, "R3 carry into boundary w16");
      v16(16'(32'd3 << bnd[k]), 16'(32'd1 << bnd[k]), 1'b0, "R5 raw leg w16");
      v16(grp_all, 16'd0, 1'b1, "R6 add-one ripples across group w16");
    end
  endtask

  // R1: pseudo-random operands
  task automatic t_random;
    for (int n = 0; n < 2000; n++) begin
      v32($urandom, $urandom, 1'($urandom), "R1 random w32");
      v16(16'($urandom), 16'($urandom), 1'($urandom), "R1 random w16");
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    t_reset_zero();
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_corners();
    t_edges32();
    t_edges16();
    t_random();
    t_exhaustive8();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule